// File: doc/BRIEF.md
# Eight-Operation Accumulator Processor Core

This block is a compact 8-bit processor built around a single accumulator. Every instruction is two bytes long. The first byte carries a 3-bit operation code in its top bits and the upper five bits of a 13-bit operand address. The second byte carries the low eight address bits. The core reads instruction bytes and operand bytes over one shared 8-bit bidirectional data bus. The same bus carries the accumulator out on stores.

Program and data memories are outside the block. The surrounding system decodes the 13-bit address. Addresses with the top two bits equal to `11` reach a 1 KB data RAM, indexed by the low ten bits. Every other address reaches program ROM. A fixed eight-step controller runs each instruction. A `fetch` output marks the two byte-fetch steps. While `fetch` is high the address bus carries the program counter, and at all other times it carries the operand address. A `halt` output rises when the stop operation is decoded, and execution freezes there until reset.

Top module: `acc8_core`

## Requirements
- R1: While reset (active high, asynchronous) is asserted, and before the first edge after its release, `pc_addr`, `ir_addr` and `opcode` read 0, `halt` and `wr` read 0, and `fetch` reads 1. The accumulator is cleared, so a store executed first writes 0x00.
- R2: An instruction is fetched as two bytes at consecutive program addresses. The program counter grows by one after each byte, so it is odd during the second fetch step. Afterwards `opcode` equals first-byte bits [7:5], and `ir_addr` equals {first-byte bits [4:0], second byte}.
- R3: `addr` equals `pc_addr` in every cycle where `fetch` is 1, and equals `ir_addr` in every cycle where `fetch` is 0.
- R4: Code 010 adds the operand byte to the accumulator modulo 256. Code 011 ANDs the operand byte into the accumulator, and code 100 XORs it in.
- R5: Code 101 loads the operand byte into the accumulator. The operand byte may come from RAM or from ROM space.
- R6: Code 110 drives the accumulator onto `data` and gives exactly one single-cycle `wr` pulse per store. The bus already holds the value when `wr` rises, so a memory that captures on the rising edge of `wr` stores the accumulator.
- R7: Code 111 loads `ir_addr` into the program counter, so the next fetch starts at the operand address.
- R8: Code 001 skips the following two-byte instruction when the accumulator is zero, and has no effect otherwise.
- R9: Code 000 raises `halt`. After that, `pc_addr` stays frozen and `rd`, `wr` and `fetch` stay 0 until reset.
- R10: The core drives `data` only during the execute and write-back steps of a code-110 instruction. It never drives the bus while `rd` is high.
- R11: Every non-halting instruction takes exactly eight clock cycles, so `fetch` rises once every eight cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| addr | output | 13 | Memory address: program counter during fetch, operand address otherwise |
| data | inout | 8 | Shared data bus, driven by the core only during stores |
| rd | output | 1 | Read strobe, high during byte fetches and operand reads |
| wr | output | 1 | Write strobe, one-cycle pulse per store |
| fetch | output | 1 | High during the two instruction-byte fetch steps |
| halt | output | 1 | High once the stop operation has been decoded |
| opcode | output | 3 | Operation code of the current instruction |
| pc_addr | output | 13 | Program counter |
| ir_addr | output | 13 | Operand address of the current instruction |

## Verification
Two functions meet in one window: the bus hand-over from a memory read to a store, and the rising write strobe. The memory drives `data` on the operand read, and the core must then own the bus before `wr` rises. The bench provokes this by following every arithmetic operation directly with a store. It sweeps operand pairs over the whole byte range through the add, AND and XOR codes, and compares each stored byte with the value computed arithmetically. A store that captured a stale or contended bus value would show up as a wrong byte. A second pairing is the skip test meeting an accumulator just loaded by the preceding instruction. Every loadable byte is swept through that path, and a Fibonacci loop uses the same zero test as its exit condition.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_HLT = 3'b000,
        OP_SKZ = 3'b001,
        OP_ADD = 3'b010,
        OP_AND = 3'b011,
        OP_XOR = 3'b100,
        OP_LDA = 3'b101,
        OP_STO = 3'b110,
        OP_JMP = 3'b111
    } op_e;

    typedef enum logic [2:0] {
        ST_FHI  = 3'd0,
        ST_FLO  = 3'd1,
        ST_DEC  = 3'd2,
        ST_OPRD = 3'd3,
        ST_EXEC = 3'd4,
        ST_WB   = 3'd5,
        ST_PCUP = 3'd6,
        ST_GAP  = 3'd7
    } st_e;

    // operations that take an operand byte from memory
    function automatic logic reads_mem(op_e op);
        return (op == OP_ADD) || (op == OP_AND) || (op == OP_XOR) || (op == OP_LDA);
    endfunction

    // operations whose result lands in the accumulator
    function automatic logic loads_acc(op_e op);
        return reads_mem(op);
    endfunction

endpackage

// File: rtl/acc8_alu.sv
module acc8_alu
    import acc8_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    output logic [DW-1:0] y
);

    always_comb begin
        unique case (op)
            OP_ADD:  y = acc + opnd;
            OP_AND:  y = acc & opnd;
            OP_XOR:  y = acc ^ opnd;
            OP_LDA:  y = opnd;
            default: y = acc;
        endcase
    end

endmodule

// File: rtl/acc8_ctrl.sv
module acc8_ctrl
    import acc8_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    output st_e  state,
    output logic halted,
    output logic rd_o,
    output logic wr_o,
    output logic fetch_o,
    output logic drive_o
);

    typedef struct packed {
        st_e  st;
        logic halt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_FHI:  ctl_d.st = ST_FLO;
            ST_FLO:  ctl_d.st = ST_DEC;
            ST_DEC: begin
                if (op == OP_HLT) begin
                    ctl_d.halt = 1'b1;
                    ctl_d.st   = ST_DEC;
                end else begin
                    ctl_d.st = ST_OPRD;
                end
            end
            ST_OPRD: ctl_d.st = ST_EXEC;
            ST_EXEC: ctl_d.st = ST_WB;
            ST_WB:   ctl_d.st = ST_PCUP;
            ST_PCUP: ctl_d.st = ST_GAP;
            ST_GAP:  ctl_d.st = ST_FHI;
            default: ctl_d.st = ST_FHI;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ctl_q <= '{st: ST_FHI, halt: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state   = ctl_q.st;
    assign halted  = ctl_q.halt;
    assign fetch_o = (ctl_q.st == ST_FHI) || (ctl_q.st == ST_FLO);
    assign rd_o    = fetch_o || ((ctl_q.st == ST_OPRD) && reads_mem(op));
    assign drive_o = ((ctl_q.st == ST_EXEC) || (ctl_q.st == ST_WB)) && (op == OP_STO);
    assign wr_o    = (ctl_q.st == ST_WB) && (op == OP_STO);

endmodule

// File: rtl/acc8_dpath.sv
module acc8_dpath
    import acc8_pkg::*;
#(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  st_e           state,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] opnd_adr,
    output op_e           op,
    output logic [DW-1:0] acc
);

    localparam int HI_W = AW - DW;

    typedef struct packed {
        logic [AW-1:0] pc;
        op_e           op;
        logic [AW-1:0] adr;
        logic [DW-1:0] mdr;
        logic [DW-1:0] res;
        logic [DW-1:0] acc;
    } dp_t;

    dp_t           dp_d, dp_q;
    logic [DW-1:0] alu_y;

    acc8_alu #(.DW(DW)) u_alu (
        .op   (dp_q.op),
        .acc  (dp_q.acc),
        .opnd (dp_q.mdr),
        .y    (alu_y)
    );

    always_comb begin
        dp_d = dp_q;
        unique case (state)
            ST_FHI: begin
                dp_d.op             = op_e'(din[DW-1 -: OP_W]);
                dp_d.adr[AW-1:DW]   = din[HI_W-1:0];
                dp_d.pc             = dp_q.pc + 1'b1;
            end
            ST_FLO: begin
                dp_d.adr[DW-1:0] = din;
                dp_d.pc          = dp_q.pc + 1'b1;
            end
            ST_OPRD: begin
                if (reads_mem(dp_q.op)) dp_d.mdr = din;
            end
            ST_EXEC: begin
                dp_d.res = alu_y;
            end
            ST_WB: begin
                if (loads_acc(dp_q.op)) dp_d.acc = dp_q.res;
            end
            ST_PCUP: begin
                if (dp_q.op == OP_JMP) begin
                    dp_d.pc = dp_q.adr;
                end else if ((dp_q.op == OP_SKZ) && (dp_q.acc == '0)) begin
                    dp_d.pc = dp_q.pc + AW'(2);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            dp_q <= '{pc: '0, op: OP_HLT, adr: '0, mdr: '0, res: '0, acc: '0};
        end else begin
            dp_q <= dp_d;
        end
    end

    assign pc       = dp_q.pc;
    assign opnd_adr = dp_q.adr;
    assign op       = dp_q.op;
    assign acc      = dp_q.acc;

endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_pkg::*;
#(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] addr,
    inout  wire  [DW-1:0] data,
    output logic          rd,
    output logic          wr,
    output logic          fetch,
    output logic          halt,
    output logic [2:0]    opcode,
    output logic [AW-1:0] pc_addr,
    output logic [AW-1:0] ir_addr
);

    st_e           state;
    op_e           op;
    logic          drive;
    logic [DW-1:0] acc;
    logic [AW-1:0] pc;
    logic [AW-1:0] opnd_adr;

    acc8_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .state   (state),
        .halted  (halt),
        .rd_o    (rd),
        .wr_o    (wr),
        .fetch_o (fetch),
        .drive_o (drive)
    );

    acc8_dpath #(.AW(AW), .DW(DW)) u_dpath (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .din      (data),
        .pc       (pc),
        .opnd_adr (opnd_adr),
        .op       (op),
        .acc      (acc)
    );

    assign data    = drive ? acc : {DW{1'bz}};
    assign addr    = fetch ? pc : opnd_adr;
    assign opcode  = op;
    assign pc_addr = pc;
    assign ir_addr = opnd_adr;

endmodule

// File: rtl/acc8_chk.sv
module acc8_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          fetch,
    input logic          halt,
    input logic          rd,
    input logic          wr,
    input logic          drive,
    input logic [2:0]    opcode,
    input logic [AW-1:0] pc_addr
);

    logic [3:0] gap_q;
    logic       fetch_q;
    logic       armed_q;
    logic       rise;

    assign rise = fetch && !fetch_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            gap_q   <= 4'd0;
            fetch_q <= 1'b1;
            armed_q <= 1'b0;
        end else begin
            fetch_q <= fetch;
            if (rise) begin
                gap_q   <= 4'd1;
                armed_q <= 1'b1;
            end else if (gap_q != 4'hF) begin
                gap_q <= gap_q + 4'd1;
            end
        end
    end

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch && !halt) |=> (pc_addr == $past(pc_addr) + AW'(1)));

    // R6
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> !wr);

    // R6
    wr_src_chk: assert property (@(posedge clk) disable iff (rst)
        wr |-> (opcode == 3'b110 && drive && !rd));

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> (halt && $stable(pc_addr) && !rd && !wr && !fetch));

    // R10
    bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
        drive |-> (opcode == 3'b110 && !rd && !fetch));

    // R11
    slot_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && armed_q) |-> (gap_q == 4'd8));

endmodule

bind acc8_core acc8_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .fetch   (fetch),
    .halt    (halt),
    .rd      (rd),
    .wr      (wr),
    .drive   (drive),
    .opcode  (opcode),
    .pc_addr (pc_addr)
);

// File: tb/acc8_core_test.sv
`timescale 1ns/1ps
module acc8_core_test;

    localparam int ADD_C = 2, AND_C = 3, XOR_C = 4, LDA_C = 5, STO_C = 6, JMP_C = 7;
    localparam int SKZ_C = 1, HLT_C = 0;
    localparam logic [12:0] RB = 13'h1800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    wire  [12:0] addr;
    wire  [7:0]  bus;
    wire         rd, wr, fetch, halt;
    wire  [2:0]  opcode;
    wire  [12:0] pc_addr, ir_addr;

    logic [7:0] rom [1024];
    logic [7:0] ram [1024];
    int tests = 0, fails = 0;
    int wr_cnt, gap_e, mux_e, run_n;
    bit finished = 0;

    wire ram_sel = (addr[12:11] == 2'b11);

    assign bus = (rd && ram_sel) ? ram[addr[9:0]] : (rd ? rom[addr[9:0]] : 8'hzz);

    always @(posedge wr) begin
        if (ram_sel) ram[addr[9:0]] = bus;
        wr_cnt = wr_cnt + 1;
    end

    always #4 clk = ~clk;

    acc8_core uut (
        .clk(clk), .rst(rst), .addr(addr), .data(bus), .rd(rd), .wr(wr),
        .fetch(fetch), .halt(halt), .opcode(opcode), .pc_addr(pc_addr), .ir_addr(ir_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) begin
            rom[i] = 8'h00;
            ram[i] = 8'hEE;
        end
    endtask

    task automatic put(input int slot, input int op, input logic [12:0] a);
        rom[2*slot]   = {op[2:0], a[12:8]};
        rom[2*slot+1] = a[7:0];
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // runs from reset until halt; tracks address mux and fetch spacing
    task automatic run_prog(input int limit);
        int  last;
        logic fp;
        wr_cnt = 0; gap_e = 0; mux_e = 0; run_n = 0;
        do_reset();
        last = -1; fp = 1'b0;
        while (run_n < limit) begin
            if (addr !== (fetch ? pc_addr : ir_addr)) mux_e++;
            if (fetch && !fp) begin
                if (last >= 0 && (run_n - last) != 8) gap_e++;
                last = run_n;
            end
            fp = fetch;
            if (halt) break;
            @(negedge clk);
            run_n++;
        end
        if (!halt) chk("run did not halt", 0, 1);
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        clear_mem();
        // R1: reset state and a store executed first writes the cleared accumulator
        put(0, STO_C, RB);
        put(1, HLT_C, 13'd0);
        ram[0] = 8'hFF;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 pc_addr in reset", pc_addr, 0);
        chk("R1 ir_addr in reset", ir_addr, 0);
        chk("R1 opcode in reset", opcode, 0);
        chk("R1 halt/wr/fetch in reset", {halt, wr, fetch}, 3'b001);
        run_prog(200);
        chk("R1 accumulator cleared", ram[0], 8'h00);

        // R2: two-byte fetch timing, odd pc on second byte, field split
        clear_mem();
        put(0, LDA_C, 13'h1A05);
        put(1, HLT_C, 13'd0);
        do_reset();
        chk("R2 first byte address", {fetch, addr}, {1'b1, 13'd0});
        @(negedge clk);
        chk("R2 second byte address odd pc", {fetch, pc_addr, addr}, {1'b1, 13'd1, 13'd1});
        @(negedge clk);
        chk("R2 opcode field", opcode, 3'd5);
        chk("R2 operand address field", ir_addr, 13'h1A05);
        chk("R2 pc after two bytes", pc_addr, 13'd2);
        chk("R3 operand on address bus", {fetch, addr}, {1'b0, 13'h1A05});

        // R4/R6/R10: sweep operand pairs through the three ALU codes, each followed by a store
        for (int opi = 0; opi < 3; opi++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    logic [7:0] a, b, e;
                    int code;
                    a = 8'(i * 17);
                    b = 8'((j * 29 + 3) & 255);
                    code = ADD_C + opi;
                    clear_mem();
                    ram[0] = a; ram[1] = b;
                    put(0, LDA_C, RB);
                    put(1, code, RB + 13'd1);
                    put(2, STO_C, RB + 13'd2);
                    put(3, HLT_C, 13'd0);
                    run_prog(200);
                    e = (opi == 0) ? 8'(a + b) : ((opi == 1) ? (a & b) : (a ^ b));
                    chk($sformatf("R4 op%0d a=%0h b=%0h", code, a, b), ram[2], e);
                    if (wr_cnt != 1) chk("R6 one wr pulse per store", wr_cnt, 1);
                    if (mux_e != 0) chk("R3 address mux", mux_e, 0);
                    if (gap_e != 0) chk("R11 eight cycles per instruction", gap_e, 0);
                end
            end
        end
        chk("R6 store count after sweep", wr_cnt, 1);
        chk("R3 address mux over sweep", mux_e, 0);
        chk("R11 instruction length over sweep", gap_e, 0);

        // R5/R10: load from ROM space, bus free during the read
        clear_mem();
        rom[13'h0100] = 8'hA7;
        put(0, LDA_C, 13'h0100);
        put(1, STO_C, RB + 13'd4);
        put(2, HLT_C, 13'd0);
        run_prog(200);
        chk("R5 load from ROM space", ram[4], 8'hA7);
        chk("R10 bus free during reads", ram[4], 8'hA7);

        // R8: skip taken only for zero accumulator, every byte value
        for (int v = 0; v < 256; v++) begin
            clear_mem();
            ram[0] = 8'(v); ram[1] = 8'h5A;
            put(0, LDA_C, RB);
            put(1, SKZ_C, 13'd0);
            put(2, LDA_C, RB + 13'd1);
            put(3, STO_C, RB + 13'd2);
            put(4, HLT_C, 13'd0);
            run_prog(200);
            chk($sformatf("R8 skip v=%0h", v), ram[2], (v == 0) ? 8'h00 : 8'h5A);
        end

        // R7: jump over a store
        clear_mem();
        ram[0] = 8'h3C;
        put(0, LDA_C, RB);
        put(1, JMP_C, 13'd6);
        put(2, STO_C, RB + 13'd3);
        put(3, STO_C, RB + 13'd2);
        put(4, HLT_C, 13'd0);
        run_prog(200);
        chk("R7 jump target executed", ram[2], 8'h3C);
        chk("R7 jumped-over store untouched", ram[3], 8'hEE);
        chk("R7 single store after jump", wr_cnt, 1);

        // R9: halt freezes the core (stop instruction in slot 4 -> pc 10)
        repeat (20) @(negedge clk);
        chk("R9 pc frozen after halt", pc_addr, 13'd10);
        chk("R9 halt held, strobes idle", {halt, rd, wr, fetch}, 4'b1000);
        chk("R9 no stores after halt", wr_cnt, 1);

        // Fibonacci loop: exit via XOR against limit and zero skip
        clear_mem();
        ram[0] = 8'd0; ram[1] = 8'd1; ram[3] = 8'd233;
        put(0, LDA_C, RB);
        put(1, ADD_C, RB + 13'd1);
        put(2, STO_C, RB + 13'd2);
        put(3, LDA_C, RB + 13'd1);
        put(4, STO_C, RB);
        put(5, LDA_C, RB + 13'd2);
        put(6, STO_C, RB + 13'd1);
        put(7, XOR_C, RB + 13'd3);
        put(8, SKZ_C, 13'd0);
        put(9, JMP_C, 13'd0);
        put(10, HLT_C, 13'd0);
        run_prog(5000);
        begin
            int fa, fb, ft, iters;
            fa = 0; fb = 1; iters = 0;
            while (fb != 233) begin
                ft = fa + fb; fa = fb; fb = ft; iters++;
            end
            chk("R8 loop final b", ram[1], fb[7:0]);
            chk("R4 loop final a", ram[0], fa[7:0]);
            chk("R6 loop store count", wr_cnt, 3 * iters);
            chk("R11 loop instruction length", gap_e, 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule